// File: doc/BRIEF.md
# Word-to-Line Memory Request Translator

This block joins a processor's word-wide memory port to a memory that only moves whole lines. It caches nothing. Each accepted processor access becomes exactly one line request in the same cycle. The line address is cut out of the byte address. A write travels as a single word lane with only that lane's bytes enabled. A read travels with no bytes enabled.

The memory answers reads only, in the order they were issued, and each answer is a full line. The translator keeps a small queue with the word position of every read still in flight. When a line returns, it pulls the matching word out of it and hands that word straight to the processor. It adds no buffering on either edge: the response path is wired straight through, and the request path is gated only by memory back-pressure and by the state of the queue.

Top module: `wline_xlate`

## Requirements
- R1: An accepted request is issued to memory in the same cycle, with mem_req_line equal to byte address bits [29:6] and mem_req_write equal to cpu_req_write. Address bits [31:30] and [1:0] have no effect on it.
- R2: For a write, with word offset ofs = address bits [5:2], mem_req_be bits 4*ofs to 4*ofs+3 are 1 and all other bits are 0.
- R3: For a write, mem_req_data bits 32*ofs to 32*ofs+31 carry cpu_req_data and all other data bits are 0.
- R4: For a read, mem_req_be is all zero.
- R5: A read response's cpu_resp_data equals mem_resp_data bits 32*ofs to 32*ofs+31, where ofs is the offset of the oldest unanswered read.
- R6: With several reads outstanding, the responses are matched to the reads in issue order, each using its own offset.
- R7: When QDEPTH (2 by default) reads are unanswered, a further read sees cpu_req_ready low and mem_req_valid low. A write is still accepted in that state.
- R8: While mem_req_ready is low, cpu_req_ready is low and nothing is recorded. Afterwards exactly QDEPTH reads are still accepted before a stall.
- R9: cpu_resp_valid follows mem_resp_valid and mem_resp_ready follows cpu_resp_ready in the same cycle. A response held off by cpu_resp_ready low keeps its queue entry.
- R10: After reset, no reads are outstanding, cpu_resp_valid is low while mem_resp_valid is low, and a read is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Processor request accepted this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_data | input | 32 | Write word |
| cpu_resp_valid | output | 1 | Read word present |
| cpu_resp_ready | input | 1 | Processor takes the read word |
| cpu_resp_data | output | 32 | Read word |
| mem_req_valid | output | 1 | Line request present |
| mem_req_ready | input | 1 | Memory takes the line request |
| mem_req_write | output | 1 | Line request is a write |
| mem_req_line | output | 24 | Line address |
| mem_req_be | output | 64 | Byte enables, one per line byte |
| mem_req_data | output | 512 | Line write data |
| mem_resp_valid | input | 1 | Line read data present |
| mem_resp_ready | output | 1 | Translator takes the line read data |
| mem_resp_data | input | 512 | Line read data |

## Verification
The bench uses the default sizes: 32-bit words, 512-bit lines, 24-bit line addresses and a two-entry offset queue. With these sizes every one of the sixteen word offsets can be swept for both writes and reads in a few hundred cycles. With a two-entry queue, the full condition is reached after only two reads, so stalls, writes passing a full queue and in-order matching of mixed offsets can all be driven directly. Expected lanes, enables and returned words are computed in the bench from a line-and-offset formula.

// File: rtl/wlx_pkg.sv
`timescale 1ns/1ps
package wlx_pkg;
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } wlx_op_e;
endpackage

// File: rtl/wlx_ofs_fifo.sv
`timescale 1ns/1ps
module wlx_ofs_fifo #(
   parameter int DEPTH = 2,
   parameter int W     = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  slot [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= step(wp);
         if (pop)  rp <= step(rp);
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) slot[wp] <= din;
   end

   assign dout  = slot[rp];
   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
endmodule

// File: rtl/wlx_lane_pack.sv
`timescale 1ns/1ps
module wlx_lane_pack #(
   parameter int WORD_W = 32,
   parameter int LANES  = 16,
   parameter int OFS_W  = 4
) (
   input  logic                      is_write,
   input  logic [OFS_W-1:0]          ofs,
   input  logic [WORD_W-1:0]         word,
   output logic [LANES*WORD_W-1:0]   line,
   output logic [LANES*WORD_W/8-1:0] be
);
   localparam int WBYTES = WORD_W / 8;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic hit;
      assign hit = is_write && (ofs == OFS_W'(g));
      assign line[g*WORD_W +: WORD_W] = hit ? word : '0;
      assign be[g*WBYTES +: WBYTES]   = {WBYTES{hit}};
   end
endmodule

// File: rtl/wlx_lane_pick.sv
`timescale 1ns/1ps
module wlx_lane_pick #(
   parameter int WORD_W      = 32,
   parameter int LANES       = 16,
   parameter int OFS_W       = 4,
   parameter bit ONEHOT_PICK = 1'b0
) (
   input  logic [LANES*WORD_W-1:0] line,
   input  logic [OFS_W-1:0]        ofs,
   output logic [WORD_W-1:0]       word
);
   if (ONEHOT_PICK) begin : g_andor
      always_comb begin
         word = '0;
         for (int i = 0; i < LANES; i++) begin
            word = word | (line[i*WORD_W +: WORD_W] & {WORD_W{ofs == OFS_W'(i)}});
         end
      end
   end else begin : g_index
      assign word = line[ofs*WORD_W +: WORD_W];
   end
endmodule

// File: rtl/wline_xlate.sv
`timescale 1ns/1ps
module wline_xlate #(
   parameter int ADDR_W      = 32,
   parameter int WORD_W      = 32,
   parameter int LINE_W      = 512,
   parameter int LADDR_W     = 24,
   parameter int QDEPTH      = 2,
   parameter bit ONEHOT_PICK = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req_valid,
   output logic                cpu_req_ready,
   input  logic                cpu_req_write,
   input  logic [ADDR_W-1:0]   cpu_req_addr,
   input  logic [WORD_W-1:0]   cpu_req_data,
   output logic                cpu_resp_valid,
   input  logic                cpu_resp_ready,
   output logic [WORD_W-1:0]   cpu_resp_data,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic                mem_req_write,
   output logic [LADDR_W-1:0]  mem_req_line,
   output logic [LINE_W/8-1:0] mem_req_be,
   output logic [LINE_W-1:0]   mem_req_data,
   input  logic                mem_resp_valid,
   output logic                mem_resp_ready,
   input  logic [LINE_W-1:0]   mem_resp_data
);
   import wlx_pkg::*;

   localparam int LANES  = LINE_W / WORD_W;
   localparam int OFS_W  = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int WB_SH  = $clog2(WORD_W / 8);
   localparam int LB_SH  = $clog2(LINE_W / 8);

   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("word width must be whole bytes");
   end
   if (LINE_W % WORD_W != 0 || (1 << $clog2(LANES)) != LANES || LANES < 2) begin : g_bad_line
      $error("line width must be a power-of-two multiple of the word width");
   end
   if (LB_SH + LADDR_W > ADDR_W) begin : g_bad_addr
      $error("line address does not fit in the byte address");
   end
   if (QDEPTH < 2) begin : g_bad_depth
      $error("offset queue needs at least two entries");
   end

   wlx_op_e          op;
   logic             q_full, q_empty, gate_ok, push, pop;
   logic [OFS_W-1:0] req_ofs, head_ofs;
   logic             unused_addr;

   assign op          = wlx_op_e'(cpu_req_write);
   assign req_ofs     = cpu_req_addr[WB_SH +: OFS_W];
   assign unused_addr = ^cpu_req_addr;

   assign gate_ok       = (op == OP_WRITE) || !q_full;
   assign mem_req_valid = cpu_req_valid && gate_ok;
   assign cpu_req_ready = mem_req_ready && gate_ok;
   assign mem_req_write = (op == OP_WRITE);
   assign mem_req_line  = cpu_req_addr[LB_SH +: LADDR_W];
   assign push          = cpu_req_valid && cpu_req_ready && (op == OP_READ);

   assign cpu_resp_valid = mem_resp_valid;
   assign mem_resp_ready = cpu_resp_ready;
   assign pop            = mem_resp_valid && cpu_resp_ready && !q_empty;

   wlx_lane_pack #(.WORD_W(WORD_W), .LANES(LANES), .OFS_W(OFS_W)) u_pack (
      .is_write (op == OP_WRITE),
      .ofs      (req_ofs),
      .word     (cpu_req_data),
      .line     (mem_req_data),
      .be       (mem_req_be)
   );

   wlx_ofs_fifo #(.DEPTH(QDEPTH), .W(OFS_W)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .din   (req_ofs),
      .dout  (head_ofs),
      .full  (q_full),
      .empty (q_empty)
   );

   wlx_lane_pick #(.WORD_W(WORD_W), .LANES(LANES), .OFS_W(OFS_W),
                   .ONEHOT_PICK(ONEHOT_PICK)) u_pick (
      .line (mem_resp_data),
      .ofs  (head_ofs),
      .word (cpu_resp_data)
   );
endmodule

// File: rtl/wline_xlate_chk.sv
`timescale 1ns/1ps
module wline_xlate_chk #(
   parameter int ADDR_W  = 32,
   parameter int WORD_W  = 32,
   parameter int LINE_W  = 512,
   parameter int LADDR_W = 24,
   parameter int QDEPTH  = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cpu_req_valid,
   input logic                cpu_req_ready,
   input logic                cpu_req_write,
   input logic [ADDR_W-1:0]   cpu_req_addr,
   input logic                mem_req_valid,
   input logic                mem_req_ready,
   input logic                mem_req_write,
   input logic [LADDR_W-1:0]  mem_req_line,
   input logic [LINE_W/8-1:0] mem_req_be,
   input logic                mem_resp_valid,
   input logic                mem_resp_ready
);
   localparam int LB_SH = $clog2(LINE_W / 8);
   localparam int CW    = $clog2(QDEPTH + 2) + 1;

   logic          cpu_fire, mem_fire, rsp_fire;
   logic [CW-1:0] inflight;

   assign cpu_fire = cpu_req_valid && cpu_req_ready;
   assign mem_fire = mem_req_valid && mem_req_ready;
   assign rsp_fire = mem_resp_valid && mem_resp_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= '0;
      else inflight <= inflight + CW'(mem_fire && !mem_req_write) - CW'(rsp_fire);
   end

   // R1
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_fire |-> mem_fire);
   // R1
   no_extra_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_fire |-> cpu_fire);
   // R1
   line_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_line == cpu_req_addr[LB_SH +: LADDR_W]) &&
                        (mem_req_write == cpu_req_write));
   // R2
   wr_be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> ($countones(mem_req_be) == WORD_W / 8));
   // R4
   rd_be_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> (mem_req_be == '0));
   // R7
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CW'(QDEPTH));
   // R7
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inflight == CW'(QDEPTH) && cpu_req_valid && !cpu_req_write) |-> !cpu_req_ready);
endmodule

bind wline_xlate wline_xlate_chk #(
   .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_W(LINE_W),
   .LADDR_W(LADDR_W), .QDEPTH(QDEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
   .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_write(mem_req_write), .mem_req_line(mem_req_line),
   .mem_req_be(mem_req_be),
   .mem_resp_valid(mem_resp_valid), .mem_resp_ready(mem_resp_ready)
);

// File: tb/wline_xlate_test.sv
`timescale 1ns/1ps
module wline_xlate_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
   logic [31:0]  cpu_req_addr = '0, cpu_req_data = '0;
   logic         cpu_req_ready, cpu_resp_valid;
   logic         cpu_resp_ready = 1'b0;
   logic [31:0]  cpu_resp_data;
   logic         mem_req_valid, mem_req_write;
   logic         mem_req_ready = 1'b0;
   logic [23:0]  mem_req_line;
   logic [63:0]  mem_req_be;
   logic [511:0] mem_req_data;
   logic         mem_resp_valid = 1'b0;
   logic         mem_resp_ready;
   logic [511:0] mem_resp_data = '0;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [23:0] exp_ln [8];
   logic [3:0]  exp_of [8];
   int qh = 0, qt = 0;

   always #10 clk = ~clk;

   wline_xlate uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
      .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
      .cpu_req_data(cpu_req_data),
      .cpu_resp_valid(cpu_resp_valid), .cpu_resp_ready(cpu_resp_ready),
      .cpu_resp_data(cpu_resp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_line(mem_req_line),
      .mem_req_be(mem_req_be), .mem_req_data(mem_req_data),
      .mem_resp_valid(mem_resp_valid), .mem_resp_ready(mem_resp_ready),
      .mem_resp_data(mem_resp_data)
   );

   function automatic logic [31:0] pat(input logic [23:0] ln, input logic [3:0] k);
      return ({8'd0, ln} * 32'h9E3779B1) ^ ({28'd0, k} * 32'h01010101) ^ 32'h5A5A0000;
   endfunction

   function automatic logic [511:0] mkline(input logic [23:0] ln);
      logic [511:0] l;
      for (int k = 0; k < 16; k++) l[k*32 +: 32] = pat(ln, 4'(k));
      return l;
   endfunction

   function automatic logic [31:0] mkaddr(input logic [1:0] hi, input logic [23:0] ln,
                                          input logic [3:0] o, input logic [1:0] lo);
      return {hi, ln, o, lo};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [511:0] act,
                      input logic [511:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_write(input logic [31:0] a, input logic [31:0] d);
      logic [511:0] ed;
      logic [63:0]  eb;
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = a; cpu_req_data = d;
      mem_req_ready = 1'b1;
      #1;
      ed = {480'd0, d} << (32 * a[5:2]);
      eb = 64'hF << (4 * a[5:2]);
      chk(cpu_req_ready && mem_req_valid && mem_req_write && mem_req_line == a[29:6],
          "R1 write issue", {487'd0, mem_req_line, cpu_req_ready},
          {487'd0, a[29:6], 1'b1});
      chk(mem_req_be == eb, "R2 write enables", {448'd0, mem_req_be}, {448'd0, eb});
      chk(mem_req_data == ed, "R3 write lane", mem_req_data, ed);
      @(negedge clk);
      cpu_req_valid = 1'b0;
   endtask

   task automatic send_read(input logic [31:0] a);
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = a;
      mem_req_ready = 1'b1;
      #1;
      chk(cpu_req_ready && mem_req_valid && !mem_req_write && mem_req_line == a[29:6],
          "R1 read issue", {487'd0, mem_req_line, cpu_req_ready},
          {487'd0, a[29:6], 1'b1});
      chk(mem_req_be == 64'd0, "R4 read enables", {448'd0, mem_req_be}, 512'd0);
      if (cpu_req_ready) begin
         exp_ln[qt % 8] = a[29:6];
         exp_of[qt % 8] = a[5:2];
         qt++;
      end
      @(negedge clk);
      cpu_req_valid = 1'b0;
   endtask

   task automatic stalled_read(input logic [31:0] a, input string req);
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = a;
      mem_req_ready = 1'b1;
      #1;
      chk(!cpu_req_ready && !mem_req_valid, req,
          {510'd0, cpu_req_ready, mem_req_valid}, 512'd0);
      @(negedge clk);
      cpu_req_valid = 1'b0;
   endtask

   task automatic give_resp(input string req);
      logic [31:0] e;
      @(negedge clk);
      mem_resp_valid = 1'b1; cpu_resp_ready = 1'b1;
      mem_resp_data  = mkline(exp_ln[qh % 8]);
      #1;
      e = pat(exp_ln[qh % 8], exp_of[qh % 8]);
      chk(cpu_resp_valid && mem_resp_ready, "R9 response pass",
          {510'd0, cpu_resp_valid, mem_resp_ready}, {510'd0, 2'b11});
      chk(cpu_resp_data == e, req, {480'd0, cpu_resp_data}, {480'd0, e});
      qh++;
      @(negedge clk);
      mem_resp_valid = 1'b0; cpu_resp_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(!cpu_resp_valid, "R10 idle response", {511'd0, cpu_resp_valid}, 512'd0);
      rst_n = 1'b1;
      send_read(mkaddr(2'b01, 24'h000123, 4'd7, 2'b10));
      chk(qt == 1, "R10 read after reset", 512'(qt), 512'd1);
      give_resp("R5 first word");

      // R1 R2 R3: write sweep over all offsets
      for (int a = 0; a < 3; a++)
         for (int o = 0; o < 16; o++)
            send_write(mkaddr(2'(a + 1), 24'h5A0000 + 24'(a * 977 + o), 4'(o), 2'(o)),
                       32'hC0DE0000 + 32'(a * 256 + o));

      // R5 R6: read sweep, pairs of mixed offsets answered in order
      for (int o = 0; o < 16; o++) begin
         send_read(mkaddr(2'(o), 24'h0F0000 + 24'(o * 31), 4'(o), 2'b01));
         send_read(mkaddr(2'(o + 2), 24'hA00000 + 24'(o * 7), 4'(15 - o), 2'b11));
         give_resp("R5 selected word");
         give_resp("R6 second in order");
      end

      // R7: full queue stalls reads, writes pass
      send_read(mkaddr(2'b00, 24'h111111, 4'd3, 2'b00));
      send_read(mkaddr(2'b00, 24'h222222, 4'd12, 2'b00));
      stalled_read(mkaddr(2'b00, 24'h333333, 4'd5, 2'b00), "R7 full stall");
      send_write(mkaddr(2'b11, 24'h444444, 4'd9, 2'b00), 32'hFEEDBEEF);
      give_resp("R6 after stall first");
      give_resp("R6 after stall second");
      send_read(mkaddr(2'b00, 24'h333333, 4'd5, 2'b00));
      give_resp("R7 read after drain");

      // R8: memory back-pressure records nothing
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b0;
      cpu_req_addr = mkaddr(2'b00, 24'h555555, 4'd1, 2'b00);
      mem_req_ready = 1'b0;
      repeat (3) begin
         #1;
         chk(!cpu_req_ready, "R8 backpressure", {511'd0, cpu_req_ready}, 512'd0);
         @(negedge clk);
      end
      cpu_req_valid = 1'b0;
      send_read(mkaddr(2'b00, 24'h666666, 4'd14, 2'b00));
      send_read(mkaddr(2'b00, 24'h777777, 4'd2, 2'b00));
      chk(qt - qh == 2, "R8 two accepted", 512'(qt - qh), 512'd2);
      stalled_read(mkaddr(2'b00, 24'h888888, 4'd0, 2'b00), "R8 nothing recorded");

      // R9: held response keeps its entry
      @(negedge clk);
      mem_resp_valid = 1'b1; cpu_resp_ready = 1'b0;
      mem_resp_data  = mkline(exp_ln[qh % 8]);
      #1;
      chk(cpu_resp_valid && !mem_resp_ready, "R9 held response",
          {510'd0, cpu_resp_valid, mem_resp_ready}, {510'd0, 2'b10});
      @(negedge clk);
      mem_resp_valid = 1'b0;
      give_resp("R9 entry kept");
      give_resp("R6 last");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule